// File: doc/BRIEF.md
# Quad Two-Stage Converter Code Register Front End

This block is the digital front end of a four-channel, 12-bit voltage-output converter. A host reaches it through a parallel word bus, a two-bit channel address, an active-low select and a read/write line. Each channel has two register stages. The first stage is the staging register, which the host writes and can read back. The second stage is the output code register, which drives the converter model downstream. One active-low load strobe moves all four staging values into the output stage together. This lets the host stage new codes one channel at a time and then change every output at the same moment. If the strobe is held low, each write reaches its output at once.

Both stages behave as level-sensitive latches. A register passes its input straight through while its enable is true and keeps the last word once the enable drops. The block builds this on a clock: a combinational path is used while the register is open, and a register holds the value when it is closed. An active-low asynchronous reset forces every register to a code chosen by a parameter, either mid-scale or zero-scale. Registers that are closed when reset is released keep that code.

The bidirectional bus is split into three ports: an input word, an output word and an output-enable. The output-enable is the tristate control for the pad.

Top module: `dacq_front`

## Requirements
- R1: The channel address `chan_sel` picks channel index 0..3 (channel A, B, C, D for values 0, 1, 2, 3; bit 1 picks the C/D pair and bit 0 picks the B/D member). Channel i appears on `dac_code[12*i+11:12*i]`.
- R2: While `sel_n`=0, `rd_wr`=0 and reset is inactive, only the addressed staging register is open. It follows `wdata` in the same cycle, with no clock delay. The other three staging registers keep their values.
- R3: When the write window closes, the staging register keeps the word that was on `wdata` at the last rising clock edge inside the window.
- R4: While `sel_n`=0 and `rd_wr`=1, `rdata_oe`=1 and `rdata` shows the addressed staging register. Otherwise `rdata_oe`=0 and `rdata`=0.
- R5: While `load_n`=0, all four output registers pass their staging values through in the same cycle. While `load_n`=1, all four hold.
- R6: With `load_n` held at 0, a write to channel X changes `dac_code` channel X in the same cycle as `wdata`, through both stages.
- R7: `arst_n`=0 forces every staging and output register to the reset code at once, whatever the other inputs are.
- R8: After `arst_n` is released, a register that stays closed keeps the reset code. Readback and outputs show that code until the register is next written or loaded.
- R9: Parameter `RESET_MID`=1 selects reset code 0x800. `RESET_MID`=0 selects 0x000.
- R10: Codes are straight binary: `wdata[0]` is the LSB and `wdata[11]` is the MSB of the 12-bit code, and each bit keeps its position in `dac_code` and `rdata`.
- R11: A word on `wdata` while `sel_n`=1, or while `rd_wr`=1, is ignored: no staging register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock used to hold latched values |
| arst_n | input | 1 | Asynchronous active-low reset to the reset code |
| sel_n | input | 1 | Active-low chip select |
| rd_wr | input | 1 | 1 = read back, 0 = write |
| load_n | input | 1 | Active-low load strobe: output stage open while low |
| chan_sel | input | 2 | Channel address |
| wdata | input | 12 | Write word from the bus |
| rdata | output | 12 | Readback word toward the bus |
| rdata_oe | output | 1 | Bus drive enable (0 means the pad is high-impedance) |
| dac_code | output | 48 | Four output codes, channel i in bits [12i+11:12i] |

## Verification
The bench goes after the following corner cases:
- **Zero-latency paths.** It samples outputs inside the open window. A design that put a flop in the write path, or in the load path, would show the old code there.
- **Address decode.** It writes distinct codes to every channel and reads each one back. A swapped or mis-decoded address bit would land a code on the wrong channel.
- **Select and read/write gating.** It drives words while the block is deselected and during a read. A design that let the bus leak into the staging registers would show the stray code on the next readback.
- **Reset.** It asserts reset in the middle of a cycle and checks that every output jumps to the reset code before the next edge. After release it reads every register back. A design that reset only one stage, or released reset with a stale value, would show the old data.

// File: rtl/dacq_pkg.sv
package dacq_pkg;

  // Read/write line encoding on the host side.
  typedef enum logic {
    ACC_WRITE = 1'b0,
    ACC_READ  = 1'b1
  } acc_e;

  // Reset code for a given code width: half scale or zero.
  function automatic logic [31:0] reset_code(input int unsigned width, input bit mid);
    logic [31:0] v;
    v = '0;
    if (mid) v[width-1] = 1'b1;
    return v;
  endfunction

endpackage

// File: rtl/dacq_rst_sync.sv
module dacq_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_q_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign rst_q_n = chain_q[STAGES-1];
endmodule

// File: rtl/dacq_decode.sv
module dacq_decode
  import dacq_pkg::*;
#(
  parameter int unsigned N_CH = 4,
  localparam int unsigned AW  = (N_CH > 1) ? $clog2(N_CH) : 1
) (
  input  logic          sel_n,
  input  logic          rd_wr,
  input  logic          rst_ok,
  input  logic [AW-1:0] chan_sel,
  output logic [N_CH-1:0] wr_open,
  output logic          rd_en
);
  logic wr_cycle;

  always_comb begin
    wr_cycle = !sel_n && (acc_e'(rd_wr) == ACC_WRITE) && rst_ok;
    rd_en    = !sel_n && (acc_e'(rd_wr) == ACC_READ)  && rst_ok;
  end

  for (genvar i = 0; i < N_CH; i++) begin : g_dec
    assign wr_open[i] = wr_cycle && (chan_sel == AW'(i));
  end
endmodule

// File: rtl/dacq_latch.sv
module dacq_latch #(
  parameter int unsigned W = 12,
  parameter logic [W-1:0] RST = '0
) (
  input  logic         clk,
  input  logic         rst_q_n,
  input  logic         open,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] held_q;
  logic [W-1:0] held_d;

  // Next-state: capture while open, keep otherwise.
  always_comb begin
    held_d = open ? d : held_q;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) held_q <= RST;
    else          held_q <= held_d;
  end

  // Transparent path while open, held word when closed, reset code while reset.
  always_comb begin
    if (!rst_q_n)  q = RST;
    else if (open) q = d;
    else           q = held_q;
  end
endmodule

// File: rtl/dacq_front.sv
module dacq_front
  import dacq_pkg::*;
#(
  parameter int unsigned N_CH      = 4,
  parameter int unsigned W         = 12,
  parameter bit          RESET_MID = 1'b1,
  localparam int unsigned AW       = (N_CH > 1) ? $clog2(N_CH) : 1,
  localparam logic [W-1:0] RST     = W'(reset_code(W, RESET_MID))
) (
  input  logic            clk,
  input  logic            arst_n,
  input  logic            sel_n,
  input  logic            rd_wr,
  input  logic            load_n,
  input  logic [AW-1:0]   chan_sel,
  input  logic [W-1:0]    wdata,
  output logic [W-1:0]    rdata,
  output logic            rdata_oe,
  output logic [N_CH*W-1:0] dac_code
);
  logic            rst_q_n;
  logic [N_CH-1:0] wr_open;
  logic            rd_en;
  logic [W-1:0]    stage_q [N_CH];
  logic            load_open;

  dacq_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .arst_n (arst_n),
    .rst_q_n(rst_q_n)
  );

  dacq_decode #(.N_CH(N_CH)) u_dec (
    .sel_n   (sel_n),
    .rd_wr   (rd_wr),
    .rst_ok  (rst_q_n),
    .chan_sel(chan_sel),
    .wr_open (wr_open),
    .rd_en   (rd_en)
  );

  assign load_open = !load_n && rst_q_n;

  for (genvar i = 0; i < N_CH; i++) begin : g_ch
    logic [W-1:0] out_q;

    dacq_latch #(.W(W), .RST(RST)) u_stage (
      .clk    (clk),
      .rst_q_n(rst_q_n),
      .open   (wr_open[i]),
      .d      (wdata),
      .q      (stage_q[i])
    );

    dacq_latch #(.W(W), .RST(RST)) u_out (
      .clk    (clk),
      .rst_q_n(rst_q_n),
      .open   (load_open),
      .d      (stage_q[i]),
      .q      (out_q)
    );

    assign dac_code[i*W +: W] = out_q;
  end

  always_comb begin
    rdata_oe = rd_en;
    rdata    = rd_en ? stage_q[chan_sel] : '0;
  end
endmodule

// File: rtl/dacq_front_chk.sv
module dacq_front_chk #(
  parameter int unsigned N_CH      = 4,
  parameter int unsigned W         = 12,
  parameter bit          RESET_MID = 1'b1,
  localparam int unsigned AW       = (N_CH > 1) ? $clog2(N_CH) : 1,
  localparam logic [W-1:0] RST     = RESET_MID ? (W'(1) << (W-1)) : '0
) (
  input logic            clk,
  input logic            arst_n,
  input logic            rst_q_n,
  input logic            sel_n,
  input logic            rd_wr,
  input logic            load_n,
  input logic [AW-1:0]   chan_sel,
  input logic [W-1:0]    wdata,
  input logic [W-1:0]    rdata,
  input logic            rdata_oe,
  input logic [N_CH*W-1:0] dac_code
);
  // R2 / R6: addressed write with the load strobe low reaches the output now.
  p_write_through_r6: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!sel_n && !rd_wr && !load_n) |-> (dac_code[chan_sel*W +: W] == wdata));

  // R4: bus is driven only during a selected read.
  p_bus_idle_r4: assert property (@(posedge clk) disable iff (!rst_q_n)
    (sel_n || !rd_wr) |-> (!rdata_oe && rdata == '0));

  p_bus_drive_r4: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!sel_n && rd_wr) |-> rdata_oe);

  // R4 / R5: with the output stage open, readback equals the addressed output.
  p_readback_r5: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!sel_n && rd_wr && !load_n) |-> (rdata == dac_code[chan_sel*W +: W]));

  // R5: outputs hold while the load strobe stays high.
  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_q_n)
    (load_n && $past(load_n)) |-> $stable(dac_code));

  // R7: reset forces all outputs to the reset code.
  always @(negedge clk) begin
    if (arst_n === 1'b0) begin
      p_reset_force_r7: assert (dac_code == {N_CH{RST}});
    end
  end
endmodule

bind dacq_front dacq_front_chk #(.N_CH(N_CH), .W(W), .RESET_MID(RESET_MID)) u_chk (
  .clk     (clk),
  .arst_n  (arst_n),
  .rst_q_n (rst_q_n),
  .sel_n   (sel_n),
  .rd_wr   (rd_wr),
  .load_n  (load_n),
  .chan_sel(chan_sel),
  .wdata   (wdata),
  .rdata   (rdata),
  .rdata_oe(rdata_oe),
  .dac_code(dac_code)
);

// File: tb/dacq_front_test.sv
`timescale 1ns/1ps
module dacq_front_test;
  localparam int N = 4;
  localparam int W = 12;
  localparam logic [W-1:0] RST_MID = 12'h800;

  logic clk = 1'b0;
  logic arst_n, sel_n, rd_wr, load_n;
  logic [1:0] chan_sel;
  logic [W-1:0] wdata, rdata, rdata_z;
  logic rdata_oe, rdata_oe_z;
  logic [N*W-1:0] dac_code, dac_code_z;

  always #2.5 clk = ~clk;

  dacq_front uut (
    .clk(clk), .arst_n(arst_n), .sel_n(sel_n), .rd_wr(rd_wr), .load_n(load_n),
    .chan_sel(chan_sel), .wdata(wdata), .rdata(rdata), .rdata_oe(rdata_oe),
    .dac_code(dac_code)
  );

  dacq_front #(.RESET_MID(1'b0)) uut_zero (
    .clk(clk), .arst_n(arst_n), .sel_n(1'b1), .rd_wr(1'b1), .load_n(1'b1),
    .chan_sel(2'd0), .wdata(12'h0), .rdata(rdata_z), .rdata_oe(rdata_oe_z),
    .dac_code(dac_code_z)
  );

  // Scoreboard: sel 0..3 = output channel, 4 = rdata, 5 = rdata_oe, 6 = zero-reset instance all channels
  typedef struct {
    int          sel;
    logic [47:0] exp;
    string       req;
  } item_t;

  item_t q[$];
  event chk_ev;
  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  logic [W-1:0] m_stage [N];
  logic [W-1:0] m_out [N];

  task automatic expect_item(input int sel, input logic [47:0] exp, input string req);
    item_t it;
    it.sel = sel; it.exp = exp; it.req = req;
    q.push_back(it);
    ->chk_ev;
    #0.1;
  endtask

  initial begin
    forever begin
      @(chk_ev);
      while (q.size() > 0) begin
        item_t it;
        logic [47:0] act;
        it = q.pop_front();
        case (it.sel)
          0, 1, 2, 3: act = 48'(dac_code[it.sel*W +: W]);
          4:          act = 48'(rdata);
          5:          act = 48'(rdata_oe);
          default:    act = 48'(dac_code_z);
        endcase
        n_chk++;
        if (act !== it.exp) begin
          n_err++;
          $display("FAIL %s sel=%0d actual=%h expected=%h", it.req, it.sel, act, it.exp);
        end
      end
    end
  end

  task automatic check_outs(input string req);
    for (int i = 0; i < N; i++) expect_item(i, 48'(m_out[i]), req);
  endtask

  // Write one channel; checks the open window, then the held value.
  task automatic do_write(input int ch, input logic [W-1:0] val, input string req);
    @(negedge clk);
    sel_n = 1'b0; rd_wr = 1'b0; chan_sel = 2'(ch); wdata = val;
    m_stage[ch] = val;
    if (!load_n) m_out[ch] = val;
    #0.5;
    check_outs(req);
    @(negedge clk);
    sel_n = 1'b1; rd_wr = 1'b1; wdata = ~val;
    #0.5;
    check_outs(req);
  endtask

  task automatic do_read(input int ch, input string req);
    @(negedge clk);
    sel_n = 1'b0; rd_wr = 1'b1; chan_sel = 2'(ch);
    #0.5;
    expect_item(5, 48'd1, req);
    expect_item(4, 48'(m_stage[ch]), req);
    @(negedge clk);
    sel_n = 1'b1;
    #0.5;
    expect_item(5, 48'd0, "R4");
    expect_item(4, 48'd0, "R4");
  endtask

  task automatic do_load(input string req);
    @(negedge clk);
    load_n = 1'b0;
    for (int i = 0; i < N; i++) m_out[i] = m_stage[i];
    #0.5;
    check_outs(req);
    @(negedge clk);
    load_n = 1'b1;
    #0.5;
    check_outs(req);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: run did not finish actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    arst_n = 1'b0; sel_n = 1'b1; rd_wr = 1'b1; load_n = 1'b1;
    chan_sel = 2'd0; wdata = '0;
    for (int i = 0; i < N; i++) begin m_stage[i] = RST_MID; m_out[i] = RST_MID; end
    repeat (3) @(negedge clk);
    #0.5;
    check_outs("R7 reset state");
    expect_item(6, 48'h0, "R9 zero-scale reset");
    arst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R8: reset code persists after release in closed registers
    check_outs("R8");
    for (int i = 0; i < N; i++) do_read(i, "R8 readback");

    // R1/R2/R3: distinct codes per channel, outputs hold (load high)
    do_write(0, 12'h1A5, "R2");
    do_write(1, 12'h2B6, "R2");
    do_write(2, 12'h3C7, "R1");
    do_write(3, 12'h4D8, "R1");
    for (int i = 0; i < N; i++) do_read(i, "R1/R3 readback");
    do_load("R5");

    // R10: bit order
    do_write(2, 12'h001, "R10");
    do_write(1, 12'h800, "R10");
    do_load("R10");

    // R11: deselected and read-phase words are ignored
    @(negedge clk);
    sel_n = 1'b1; rd_wr = 1'b0; chan_sel = 2'd1; wdata = 12'h777;
    repeat (2) @(negedge clk);
    rd_wr = 1'b1;
    do_read(1, "R11");
    @(negedge clk);
    sel_n = 1'b0; rd_wr = 1'b1; chan_sel = 2'd3; wdata = 12'h555;
    repeat (2) @(negedge clk);
    sel_n = 1'b1;
    do_read(3, "R11");

    // R6: load held low, write flows through both stages
    @(negedge clk);
    load_n = 1'b0;
    for (int i = 0; i < N; i++) m_out[i] = m_stage[i];
    do_write(3, 12'hFFF, "R6");
    do_write(0, 12'h000, "R6");
    @(negedge clk);
    load_n = 1'b1;

    // R5: stage new codes, outputs hold until a load
    do_write(1, 12'h0F0, "R5 hold");
    do_write(2, 12'hABC, "R5 hold");
    do_load("R5 update");

    // R7: mid-cycle asynchronous reset with a write in progress
    @(negedge clk);
    sel_n = 1'b0; rd_wr = 1'b0; chan_sel = 2'd2; wdata = 12'h123; load_n = 1'b0;
    #1;
    arst_n = 1'b0;
    for (int i = 0; i < N; i++) begin m_stage[i] = RST_MID; m_out[i] = RST_MID; end
    #0.5;
    check_outs("R7 async");
    @(negedge clk);
    sel_n = 1'b1; rd_wr = 1'b1; load_n = 1'b1;
    @(negedge clk);
    arst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_outs("R8 after reset");
    for (int i = 0; i < N; i++) do_read(i, "R8 readback");
    expect_item(6, 48'h0, "R9");

    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule